// File: doc/BRIEF.md
# Two-Bank SPI Configuration Registers

This block is a four-wire serial slave that holds the configuration words of a larger chip. A host controller sends 16-bit frames with an active-low chip select. Each frame carries a direction flag, a 5-bit address and a 10-bit data word. Writes land in a register array whose contents are visible in parallel to the surrounding logic. Reads return a stored word on the serial output.

The array is split into two banks: a main bank of `MAIN` words and a local bank of `LOCAL` words. Bit 0 of main register 0 decides which bank the 5-bit address refers to, so more than 32 words can be reached with a 5-bit address. Register 0 always stays in the main bank, so the bank bit can be changed from either bank.

All serial pins are resampled by the system clock. A write takes effect only when chip select returns high after a complete frame. Each committed write raises a one-cycle strobe that also carries the bank and address, so downstream logic can react to the change. Register contents have no reset and keep their values until they are written again.

Top module: `spi_cfg_regs`

## Requirements
- R1: A frame is 16 bits, sent MSB first on `spi_din` and sampled on rising `spi_sclk` edges while `spi_csn` is low. Bit 15 selects the direction (1 = read, 0 = write), bits 14:10 hold the address and bits 9:0 hold the data.
- R2: A write frame changes the addressed register only when `spi_csn` rises. After the 16th bit has arrived and before `spi_csn` rises, the contents are unchanged.
- R3: A frame that ends with fewer than 16 bits is discarded. It writes nothing and raises no strobe.
- R4: When main register 0 bit 0 is 0, address n selects main register n. When it is 1, address n in 1..`LOCAL` selects local register n-1.
- R5: Address 0 selects main register 0 whatever the value of the bank bit.
- R6: In the local bank, an address above `LOCAL` selects nothing. A write to it changes no register and raises no strobe, and a read of it returns all zeros.
- R7: In a read frame, the addressed word appears on `spi_dout` as D9 first through D0 last. Each bit is updated after the falling `spi_sclk` edges that follow the 6th through the 15th rising edges. A read changes no register.
- R8: `spi_dout` is 0 during the six header bits of every frame, throughout write frames, after the data phase of a read, and whenever `spi_csn` is high.
- R9: Each committed write pulses `wr_stb` high for exactly one clock, together with `wr_bank` (0 = main, 1 = local) and `wr_addr`. Reads and discarded frames give no pulse.
- R10: `cfg_main` and `cfg_local` always show the register contents, word i at bits [10*i+9:10*i]. They change only in a cycle where `wr_stb` is high. The contents are not cleared by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the control logic (not of the contents) |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low frame select |
| spi_din | input | 1 | Serial data in |
| spi_dout | output | 1 | Serial read data out |
| cfg_main | output | MAIN*W | Parallel view of the main bank |
| cfg_local | output | LOCAL*W | Parallel view of the local bank |
| wr_stb | output | 1 | One-cycle pulse per committed write |
| wr_bank | output | 1 | Bank of the last committed write |
| wr_addr | output | 5 | Address of the last committed write |

## Verification
The bound checker watches every cycle for four things:
- the array changes only together with a strobe;
- the strobe lasts a single cycle;
- a local-bank strobe never names address 0 or an address beyond the local bank;
- a main-bank write leaves the local view untouched, and the serial output stays low while chip select is high.

Some behaviours can only be shown by the bench's directed frames:
- bit ordering and the cycle in which each read bit appears;
- a write waiting for chip select to rise;
- discarding a short frame;
- redirecting addresses by the bank bit, and reading back zeros from a missing local address.

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int MAIN  = 32,
  parameter int LOCAL = 28,
  parameter int W     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_csn,
  input  logic               spi_din,
  output logic               spi_dout,
  output logic [MAIN*W-1:0]  cfg_main,
  output logic [LOCAL*W-1:0] cfg_local,
  output logic               wr_stb,
  output logic               wr_bank,
  output logic [4:0]         wr_addr
);
  localparam int FB = 6 + W;

  logic [W-1:0] main_q  [MAIN];
  logic [W-1:0] local_q [LOCAL];

  logic [2:0]    sclk_r, cs_r;
  logic [1:0]    din_r;
  logic [4:0]    cnt;
  logic [FB-1:0] sh;
  logic [W-1:0]  rdsh;
  logic          rd_q;

  wire csn_s   = cs_r[1];
  wire s_rise  = sclk_r[1] & ~sclk_r[2];
  wire s_fall  = ~sclk_r[1] & sclk_r[2];
  wire cs_rise = cs_r[1] & ~cs_r[2];
  wire bank    = main_q[0][0];

  function automatic logic [W-1:0] rd_val(input logic [4:0] a);
    if (a == 5'd0 || !bank) return (int'(a) < MAIN) ? main_q[a] : '0;
    if (int'(a) <= LOCAL) return local_q[a - 5'd1];
    return '0;
  endfunction

  wire [4:0]   wa       = sh[FB-2:W];
  wire         wa_main  = (wa == 5'd0) || !bank;
  wire         wa_hit   = wa_main ? (int'(wa) < MAIN) : (int'(wa) <= LOCAL);
  wire         commit   = cs_rise && (cnt == 5'(FB)) && !sh[FB-1] && wa_hit;
  wire [W-1:0] rv       = rd_val(sh[4:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r   <= '0;
      cs_r     <= '1;
      din_r    <= '0;
      cnt      <= '0;
      sh       <= '0;
      rdsh     <= '0;
      rd_q     <= 1'b0;
      spi_dout <= 1'b0;
      wr_stb   <= 1'b0;
      wr_bank  <= 1'b0;
      wr_addr  <= '0;
    end else begin
      sclk_r <= {sclk_r[1:0], spi_sclk};
      cs_r   <= {cs_r[1:0], spi_csn};
      din_r  <= {din_r[0], spi_din};
      wr_stb <= 1'b0;
      if (csn_s) begin
        cnt      <= '0;
        rd_q     <= 1'b0;
        spi_dout <= 1'b0;
        if (commit) begin
          wr_stb  <= 1'b1;
          wr_bank <= !wa_main;
          wr_addr <= wa;
        end
      end else begin
        if (s_rise && cnt != 5'(FB)) begin
          sh  <= {sh[FB-2:0], din_r[1]};
          cnt <= cnt + 5'd1;
        end
        if (s_fall) begin
          if (cnt == 5'd6 && sh[5]) begin
            rd_q     <= 1'b1;
            spi_dout <= rv[W-1];
            rdsh     <= {rv[W-2:0], 1'b0};
          end else if (rd_q && cnt > 5'd6 && cnt < 5'(FB)) begin
            spi_dout <= rdsh[W-1];
            rdsh     <= {rdsh[W-2:0], 1'b0};
          end else begin
            spi_dout <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      if (wa_main) main_q[wa] <= sh[W-1:0];
      else         local_q[wa - 5'd1] <= sh[W-1:0];
    end
  end

  for (genvar i = 0; i < MAIN; i++) begin : g_main
    assign cfg_main[i*W +: W] = main_q[i];
  end
  for (genvar i = 0; i < LOCAL; i++) begin : g_local
    assign cfg_local[i*W +: W] = local_q[i];
  end
endmodule

// File: rtl/spi_cfg_regs_chk.sv
module spi_cfg_regs_chk #(
  parameter int MAIN  = 32,
  parameter int LOCAL = 28,
  parameter int W     = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csn_s,
  input logic               spi_dout,
  input logic [MAIN*W-1:0]  cfg_main,
  input logic [LOCAL*W-1:0] cfg_local,
  input logic               wr_stb,
  input logic               wr_bank,
  input logic [4:0]         wr_addr
);
  // R10
  cfg_change_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_main != $past(cfg_main) || cfg_local != $past(cfg_local)) |-> wr_stb);

  // R9
  stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R5
  local_never_addr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_bank) |-> (wr_addr != 5'd0));

  // R6
  local_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_bank) |-> (int'(wr_addr) <= LOCAL));

  // R4
  main_write_keeps_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_bank) |-> (cfg_local == $past(cfg_local)));

  // R8
  dout_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && $past(csn_s)) |-> !spi_dout);
endmodule

bind spi_cfg_regs spi_cfg_regs_chk #(.MAIN(MAIN), .LOCAL(LOCAL), .W(W)) u_chk (.*);

// File: tb/spi_cfg_regs_tb.sv
module spi_cfg_regs_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int MAIN  = 32;
  localparam int LOCAL = 28;
  localparam int W     = 10;

  logic clk = 0, rst_n = 0, sclk = 0, csn = 1, din = 0;
  logic dout, wr_stb, wr_bank;
  logic [4:0] wr_addr;
  logic [MAIN*W-1:0]  cfg_main;
  logic [LOCAL*W-1:0] cfg_local;

  int checks = 0, fails = 0, stb_cnt = 0;
  logic last_bank;
  logic [4:0] last_addr;

  spi_cfg_regs #(.MAIN(MAIN), .LOCAL(LOCAL), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_din(din),
    .spi_dout(dout), .cfg_main(cfg_main), .cfg_local(cfg_local),
    .wr_stb(wr_stb), .wr_bank(wr_bank), .wr_addr(wr_addr));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (wr_stb) begin
    stb_cnt++;
    last_bank = wr_bank;
    last_addr = wr_addr;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    #(n*CLK_P);
  endtask

  task automatic shift_frame(input logic rw, input logic [4:0] a, input logic [9:0] d,
                             input int nb, output logic [9:0] q, output int hdr_bad);
    logic [15:0] f;
    f = {rw, a, d};
    q = '0;
    hdr_bad = 0;
    csn = 0;
    wait_clk(HALF);
    for (int i = 0; i < nb; i++) begin
      sclk = 0;
      din  = f[15-i];
      wait_clk(HALF);
      if (i < 6) begin
        if (dout !== 1'b0) hdr_bad++;
      end else q[15-i] = dout;
      sclk = 1;
      wait_clk(HALF);
    end
    sclk = 0;
    wait_clk(HALF);
  endtask

  task automatic cs_up;
    csn = 1;
    wait_clk(2*HALF);
  endtask

  task automatic wr(input logic [4:0] a, input logic [9:0] d);
    logic [9:0] q;
    int hb;
    shift_frame(1'b0, a, d, 16, q, hb);
    chk("R8 dout during write", {31'd0, dout}, 0);
    cs_up();
  endtask

  task automatic rd(input logic [4:0] a, output logic [9:0] q);
    int hb;
    shift_frame(1'b1, a, 10'h0, 16, q, hb);
    chk("R8 header dout low", hb, 0);
    chk("R8 dout after data phase", {31'd0, dout}, 0);
    cs_up();
  endtask

  function automatic logic [9:0] mslot(int i);
    return cfg_main[i*W +: W];
  endfunction
  function automatic logic [9:0] lslot(int i);
    return cfg_local[i*W +: W];
  endfunction

  task automatic t_reset;
    chk("R8 dout after reset", {31'd0, dout}, 0);
    chk("R9 no strobe after reset", {31'd0, wr_stb}, 0);
  endtask

  task automatic t_main_rw;
    logic [9:0] q;
    int s0;
    wr(5'd0, 10'h000);
    s0 = stb_cnt;
    wr(5'd5, 10'h2A5);
    chk("R1 main5 written", mslot(5), 10'h2A5);
    chk("R9 one strobe", stb_cnt - s0, 1);
    chk("R9 strobe bank", {31'd0, last_bank}, 0);
    chk("R9 strobe addr", last_addr, 5);
    wr(5'd31, 10'h201);
    chk("R1 main31 written", mslot(31), 10'h201);
    s0 = stb_cnt;
    rd(5'd5, q);
    chk("R7 readback main5", q, 10'h2A5);
    rd(5'd31, q);
    chk("R7 readback main31", q, 10'h201);
    chk("R9 no strobe on read", stb_cnt - s0, 0);
    chk("R7 read keeps main5", mslot(5), 10'h2A5);
  endtask

  task automatic t_commit_edge;
    logic [9:0] q;
    int hb;
    wr(5'd7, 10'h0F0);
    shift_frame(1'b0, 5'd7, 10'h155, 16, q, hb);
    wait_clk(HALF);
    chk("R2 no change before cs rise", mslot(7), 10'h0F0);
    cs_up();
    chk("R2 change after cs rise", mslot(7), 10'h155);
  endtask

  task automatic t_short;
    logic [9:0] q;
    int hb, s0;
    s0 = stb_cnt;
    shift_frame(1'b0, 5'd7, 10'h3AA, 10, q, hb);
    cs_up();
    chk("R3 short frame no write", mslot(7), 10'h155);
    chk("R3 short frame no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_bank;
    logic [9:0] q;
    wr(5'd3, 10'h011);
    wr(5'd0, 10'h001);
    wr(5'd3, 10'h3C3);
    chk("R4 local slot 2 written", lslot(2), 10'h3C3);
    chk("R4 main3 untouched", mslot(3), 10'h011);
    chk("R4 strobe bank local", {31'd0, last_bank}, 1);
    chk("R4 strobe addr", last_addr, 3);
    rd(5'd3, q);
    chk("R4 local readback", q, 10'h3C3);
  endtask

  task automatic t_reg0;
    logic [9:0] q;
    rd(5'd0, q);
    chk("R5 addr0 reads main0 in local bank", q, 10'h001);
    wr(5'd0, 10'h000);
    chk("R5 main0 cleared", mslot(0), 10'h000);
    chk("R5 strobe bank main", {31'd0, last_bank}, 0);
    rd(5'd3, q);
    chk("R5 back in main bank", q, 10'h011);
  endtask

  task automatic t_range;
    logic [9:0] q;
    logic [LOCAL*W-1:0] lsnap;
    logic [MAIN*W-1:0]  msnap;
    int s0;
    wr(5'd0, 10'h001);
    lsnap = cfg_local;
    msnap = cfg_main;
    s0 = stb_cnt;
    wr(5'd30, 10'h3FF);
    chk("R6 local view unchanged", {31'd0, cfg_local == lsnap}, 1);
    chk("R6 main view unchanged", {31'd0, cfg_main == msnap}, 1);
    chk("R6 no strobe", stb_cnt - s0, 0);
    rd(5'd30, q);
    chk("R6 read zeros", q, 0);
    wr(5'd28, 10'h2C8);
    chk("R6 last local slot", lslot(27), 10'h2C8);
    wr(5'd0, 10'h000);
    chk("R10 bank restored", mslot(0), 0);
  endtask

  initial begin
    #(CLK_P*1000*HALF);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3;
    wait_clk(4);
    t_reset();
    rst_n = 1;
    wait_clk(4);
    t_reset();
    t_main_rw();
    t_commit_edge();
    t_short();
    t_bank();
    t_reg0();
    t_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule